// File: doc/BRIEF.md
# Register-Gated Byte-Programmed Data Window

This block sits between a microcontroller core and its external-data-memory bus. Each byte read or write either passes through to the ordinary XRAM port or is steered into an internal 2048-byte nonvolatile-style data array. The array occupies the bottom of the address space, 0x000 to 0x7FF. The choice between XRAM and array is made by an enable bit in a small control/status register that the CPU reads and writes on its own port. The cell physics is not modelled: the array is a register file.

A byte write into the array starts a timed programming interval of `PROG_CYCLES` clocks. During that interval a hardware busy flag reads as set and the array is locked. Reads of the window return 0xFF, and writes to the window are discarded. When the interval ends, the byte is committed and the flag drops. Software is expected to follow a fixed sequence:

1. Poll the busy flag.
2. Set the enable bit.
3. Make one access.
4. Clear the enable bit.

Top module: `nv_data_window`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00, with both the enable bit and the busy flag clear.
- R2: The control register has the enable bit at bit 1 and the busy flag at bit 0. A CPU write updates only bit 1. Bits 7:2 always read 0, and writing 1 to bit 0 does not set the busy flag.
- R3: With the enable bit clear, any access, including one to addresses 0x000–0x7FF, asserts the matching XRAM strobe in the same cycle. A read then returns the XRAM read data.
- R4: With the enable bit set, an access to 0x000–0x7FF asserts no XRAM strobe.
- R5: A window write accepted while not busy sets the busy flag from the next cycle. The flag stays set for exactly `PROG_CYCLES` cycles (default 16).
- R6: While busy, a window read returns 0xFF. Once the busy flag has cleared, a window read returns the byte last committed to that address.
- R7: A window write made while busy is dropped. It changes no array byte, does not extend the busy interval, and strobes no XRAM write.
- R8: With the enable bit set, addresses at or above 0x800 still go to XRAM. A write there does not set the busy flag.
- R9: Reset during programming clears the busy flag and abandons the pending byte, and the array keeps its earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | ADDR_W (16) | CPU byte address |
| busWdata | input | 8 | CPU write byte |
| busRd | input | 1 | CPU read strobe |
| busWr | input | 1 | CPU write strobe |
| busRdata | output | 8 | Read byte returned to CPU (combinational) |
| ctlWr | input | 1 | Control register write strobe |
| ctlWdata | input | 8 | Control register write value |
| ctlRdata | output | 8 | Control register read value {6'b0, enable, busy} |
| xramAddr | output | ADDR_W (16) | Address to XRAM |
| xramWdata | output | 8 | Write byte to XRAM |
| xramRd | output | 1 | XRAM read strobe |
| xramWr | output | 1 | XRAM write strobe |
| xramRdata | input | 8 | Read byte from XRAM |

## Verification
The hardest case to reach is a second window write that arrives partway through a programming interval. It must be dropped without shifting the commit time or touching its own address. The stimulus first commits a known byte to that second address. It then starts programming a different address and injects the colliding write a few cycles into the interval, while counting the busy cycles. After the interval it reads back both addresses. Reset during programming is reached in a similar way: the reset is asserted a few cycles after a write begins, and the old byte is then read back.

// File: rtl/nv_window_pkg.sv
package nv_window_pkg;

  localparam int EEE_BIT  = 1;
  localparam int BUSY_BIT = 0;
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  typedef struct packed {
    logic capture;    // latch a window write, begin programming
    logic commit;     // programming finished, store pending byte
    logic arrayRead;  // window read served by the array
    logic lockedRead; // window read while busy
  } nvStrobes_t;

endpackage

// File: rtl/nv_window_ctrl.sv
module nv_window_ctrl
  import nv_window_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 2048,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              ctlWr,
  input  logic              ctlEeeIn,
  output logic              eee,
  output logic              busy,
  output logic              xramRd,
  output logic              xramWr,
  output nvStrobes_t        strb
);

  localparam int ARR_AW = $clog2(ARRAY_BYTES);
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] progCnt;
  logic             addrHit;
  logic             inWindow;

  assign addrHit  = (busAddr[ADDR_W-1:ARR_AW] == '0);
  assign inWindow = eee && addrHit;

  always_comb begin
    strb.capture    = busWr && inWindow && !busy;
    strb.commit     = busy && (progCnt == CNT_W'(1));
    strb.arrayRead  = busRd && inWindow && !busy;
    strb.lockedRead = busRd && inWindow && busy;
    xramRd          = busRd && !inWindow;
    xramWr          = busWr && !inWindow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eee     <= 1'b0;
      busy    <= 1'b0;
      progCnt <= '0;
    end else begin
      if (ctlWr) eee <= ctlEeeIn;
      if (strb.capture) begin
        busy    <= 1'b1;
        progCnt <= CNT_W'(PROG_CYCLES);
      end else if (strb.commit) begin
        busy    <= 1'b0;
        progCnt <= '0;
      end else if (busy) begin
        progCnt <= progCnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/nv_window_dp.sv
module nv_window_dp
  import nv_window_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 2048
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic [7:0]        xramRdata,
  input  nvStrobes_t        strb,
  output logic [7:0]        busRdata
);

  localparam int ARR_AW = $clog2(ARRAY_BYTES);

  logic [7:0]        cellArr [ARRAY_BYTES];
  logic [ARR_AW-1:0] pendAddr;
  logic [7:0]        pendData;

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      pendAddr <= busAddr[ARR_AW-1:0];
      pendData <= busWdata;
    end
    if (strb.commit) cellArr[pendAddr] <= pendData;
  end

  always_comb begin
    if (strb.lockedRead)     busRdata = LOCKED_READ;
    else if (strb.arrayRead) busRdata = cellArr[busAddr[ARR_AW-1:0]];
    else                     busRdata = xramRdata;
  end

endmodule

// File: rtl/nv_data_window.sv
module nv_data_window
  import nv_window_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 2048,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busRd,
  input  logic              busWr,
  output logic [7:0]        busRdata,
  input  logic              ctlWr,
  input  logic [7:0]        ctlWdata,
  output logic [7:0]        ctlRdata,
  output logic [ADDR_W-1:0] xramAddr,
  output logic [7:0]        xramWdata,
  output logic              xramRd,
  output logic              xramWr,
  input  logic [7:0]        xramRdata
);

  nvStrobes_t strb;
  logic       eee;
  logic       busy;

  nv_window_ctrl #(
    .ADDR_W(ADDR_W), .ARRAY_BYTES(ARRAY_BYTES), .PROG_CYCLES(PROG_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .ctlWr(ctlWr), .ctlEeeIn(ctlWdata[EEE_BIT]), .eee(eee), .busy(busy),
    .xramRd(xramRd), .xramWr(xramWr), .strb(strb)
  );

  nv_window_dp #(
    .ADDR_W(ADDR_W), .ARRAY_BYTES(ARRAY_BYTES)
  ) dp_i (
    .clk(clk), .busAddr(busAddr), .busWdata(busWdata), .xramRdata(xramRdata),
    .strb(strb), .busRdata(busRdata)
  );

  always_comb begin
    ctlRdata           = '0;
    ctlRdata[EEE_BIT]  = eee;
    ctlRdata[BUSY_BIT] = busy;
  end

  assign xramAddr  = busAddr;
  assign xramWdata = busWdata;

endmodule

// File: rtl/nv_data_window_chk.sv
module nv_data_window_chk #(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 2048
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [7:0]        busRdata,
  input logic [7:0]        ctlRdata,
  input logic              xramRd,
  input logic              xramWr,
  input logic [7:0]        xramRdata
);

  logic hit;
  assign hit = ctlRdata[1] && (32'(busAddr) < ARRAY_BYTES);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rstN |=> (ctlRdata == 8'h00));

  assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdata[7:2] == 6'b0);

  assert_xram_passthrough_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !hit) |-> (xramRd && busRdata == xramRdata));

  assert_window_no_xram_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((busRd || busWr) && hit) |-> (!xramRd && !xramWr));

  assert_busy_needs_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlRdata[0]) |-> $past(busWr && hit));

  assert_locked_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && hit && ctlRdata[0]) |-> (busRdata == 8'hFF));

  assert_high_write_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !hit && !ctlRdata[0]) |=> !ctlRdata[0]);

endmodule

bind nv_data_window nv_data_window_chk #(
  .ADDR_W(ADDR_W), .ARRAY_BYTES(ARRAY_BYTES)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busRdata(busRdata), .ctlRdata(ctlRdata), .xramRd(xramRd), .xramWr(xramWr),
  .xramRdata(xramRdata)
);

// File: tb/nv_data_window_tb.sv
module nv_data_window_tb_top;

  localparam int PROG = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic        busRd = 1'b0, busWr = 1'b0, ctlWr = 1'b0;
  logic [7:0]  ctlWdata = '0;
  logic [7:0]  busRdata, ctlRdata, xramWdata;
  logic [15:0] xramAddr;
  logic        xramRd, xramWr;
  logic [7:0]  xramRdata;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign xramRdata = xramAddr[7:0] ^ 8'h5A;

  nv_data_window #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busRd(busRd), .busWr(busWr), .busRdata(busRdata), .ctlWr(ctlWr),
    .ctlWdata(ctlWdata), .ctlRdata(ctlRdata), .xramAddr(xramAddr),
    .xramWdata(xramWdata), .xramRd(xramRd), .xramWr(xramWr),
    .xramRdata(xramRdata)
  );

  typedef struct packed {
    logic        eeeOn;
    logic        isWr;
    logic [15:0] addr;
    logic        expXram;
    logic        chkData;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b1},  // R3
    '{1'b0, 1'b0, 16'h07FF, 1'b1, 1'b1},  // R3
    '{1'b0, 1'b1, 16'h0123, 1'b1, 1'b0},  // R3
    '{1'b1, 1'b0, 16'h0800, 1'b1, 1'b1},  // R8
    '{1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b1},  // R8
    '{1'b1, 1'b1, 16'h0900, 1'b1, 1'b0},  // R8
    '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0},  // R4
    '{1'b1, 1'b0, 16'h07FF, 1'b0, 1'b0}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic ctlWrite(input logic [7:0] v);
    @(negedge clk); ctlWr = 1'b1; ctlWdata = v;
    @(negedge clk); ctlWr = 1'b0;
  endtask

  // write spans one rising edge; returns the XRAM write strobe seen during it
  task automatic busWrite(input logic [15:0] a, input logic [7:0] d, output logic xw);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    #1 xw = xramWr;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d, output logic xr);
    @(negedge clk); busRd = 1'b1; busAddr = a;
    #1 d = busRdata; xr = xramRd;
    busRd = 1'b0;
  endtask

  task automatic waitIdle(output int cycles);
    cycles = 0;
    #1;
    while (ctlRdata[0] && cycles < 200) begin
      cycles++;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    logic xs;
    int cyc;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 chk("R1 reset value", ctlRdata, 8'h00);

    // R2: register layout
    ctlWrite(8'hFF);
    #1 chk("R2 enable readback", ctlRdata, 8'h02);
    ctlWrite(8'h01);
    #1 chk("R2 busy not writable", ctlRdata, 8'h00);

    // table walk: routing
    foreach (VECS[i]) begin
      ctlWrite(VECS[i].eeeOn ? 8'h02 : 8'h00);
      if (VECS[i].isWr) begin
        busWrite(VECS[i].addr, 8'hA5, xs);
        chk(VECS[i].eeeOn ? "R8 xram write strobe" : "R3 xram write strobe", xs, VECS[i].expXram);
        @(negedge clk); #1;
        chk("R8 no busy from xram write", ctlRdata[0], 1'b0);
      end else begin
        busRead(VECS[i].addr, rd, xs);
        chk(VECS[i].expXram ? "R3/R8 xram read strobe" : "R4 window read no strobe", xs, VECS[i].expXram);
        if (VECS[i].chkData)
          chk("R3 xram read data", rd, VECS[i].addr[7:0] ^ 8'h5A);
      end
    end

    // R5 / R6: program one byte
    ctlWrite(8'h02);
    busWrite(16'h0010, 8'h3C, xs);
    chk("R4 window write no strobe", xs, 1'b0);
    #1 chk("R5 busy set after write", ctlRdata[0], 1'b1);
    busRead(16'h0010, rd, xs);
    chk("R6 locked read 0xFF", rd, 8'hFF);
    waitIdle(cyc);
    chk("R5 busy length", cyc, PROG - 1);  // one busy cycle consumed by the read above
    busRead(16'h0010, rd, xs);
    chk("R6 committed byte", rd, 8'h3C);

    // R7 setup: known byte at B
    busWrite(16'h0020, 8'h11, xs);
    waitIdle(cyc);
    chk("R5 busy length plain", cyc, PROG);

    // R7: colliding write during programming
    busWrite(16'h0010, 8'h77, xs);
    cyc = 0;
    #1;
    while (ctlRdata[0] && cyc < 200) begin
      cyc++;
      if (cyc == 4) begin
        busWr = 1'b1; busAddr = 16'h0020; busWdata = 8'hEE;
        #0.5 chk("R7 dropped write no xram strobe", xramWr, 1'b0);
        @(negedge clk); busWr = 1'b0; #1;
      end else begin
        @(negedge clk); #1;
      end
    end
    chk("R7 busy not extended", cyc, PROG);
    busRead(16'h0020, rd, xs);
    chk("R7 dropped byte unchanged", rd, 8'h11);
    busRead(16'h0010, rd, xs);
    chk("R6 second commit", rd, 8'h77);

    // R9: reset mid-programming
    busWrite(16'h0020, 8'h99, xs);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1 chk("R9 reset clears busy and enable", ctlRdata, 8'h00);
    ctlWrite(8'h02);
    repeat (PROG + 2) @(negedge clk);
    busRead(16'h0020, rd, xs);
    chk("R9 array kept, pending dropped", rd, 8'h11);

    finishRun();
  end

endmodule